// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software by watching for periodic refresh writes. Once enabled, it holds a deadline equal to the value of a 64-bit free-running system counter plus a 48-bit offset. If the counter reaches that deadline, the first stage fires: a warning status flag is set, an interrupt is raised and a new deadline, one offset period later, is armed. If that second period also elapses without service, the second stage fires: a second status flag is set and a reset request is driven for the system to act upon.

Software reaches the block through a simple 32-bit word bus with two frames, chosen by a frame-select input. The refresh frame carries the refresh register and an identification word. The control frame carries the control/status word, the offset (split into a low and a high word), the 64-bit compare value (split into two words) and the identification word. Any refresh, enable write or offset write restarts the countdown from the current counter value and copies the new deadline into the compare words, where software can read it back.

Top module: `wdog_top`

## Requirements
- R1: After reset, the control/status, both offset words and both compare words read zero, `wdog_irq` and `wdog_rst_req` are low, and the identification word at address 0xFFC reads the `ID_VALUE` parameter in either frame.
- R2: The offset is 48 bits: control address 0x008 holds bits 31:0 and control address 0x00C holds bits 47:32; written bits 31:16 of the high word are dropped and read back as zero.
- R3: A write of any data to refresh address 0x000 clears both status flags and leaves `wdog_irq` unchanged; when enabled, it sets the deadline to counter plus offset and stores it in the compare words (0x010 low half, 0x014 high half).
- R4: A read of refresh address 0x000 returns zero and changes no state.
- R5: A write to control address 0x000 keeps only data bit 0 as enable, clears both status flags, lowers `wdog_irq` and performs a refresh; the word reads back with enable in bit 0, the first-stage flag in bit 1, the second-stage flag in bit 2 and zero elsewhere.
- R6: A write to either offset word clears both status flags, lowers `wdog_irq` and performs a refresh using the new offset value.
- R7: When enabled and the counter is at or past the deadline with the first-stage flag clear, the first-stage flag and `wdog_irq` are set on the next clock edge, the deadline becomes counter plus offset, and the compare words are left unchanged.
- R8: When the deadline is reached with the first-stage flag already set, the second-stage flag and `wdog_rst_req` are set and no further deadline is armed.
- R9: With enable clear, no deadline fires, whatever the counter value.
- R10: Writes to the compare words change only the stored value read back; the pending deadline is unaffected.
- R11: Accesses with address bits 1:0 not zero, or to addresses not listed, read zero and leave all state unchanged.
- R12: When a refresh, control/status or offset write lands in the same cycle as a deadline hit, the write wins and the hit is dropped; a compare-word write in the same cycle as a first-stage hit takes effect alongside it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_cnt | input | 64 | Free-running system counter value |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_frame | input | 1 | Frame select: 0 refresh frame, 1 control frame |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the request |
| wdog_irq | output | 1 | First-stage interrupt, level |
| wdog_rst_req | output | 1 | Second-stage reset request, level |

## Verification
The two functions that can coincide are a bus write and a deadline hit decided in the same clock edge. The bench provokes this by setting the counter to exactly the current deadline in the same cycle it issues a refresh write, and again with a compare-word write. It judges the first case by reading back a clear status word, a low interrupt and a compare value one offset period past the write-cycle counter, and the second by reading a set first-stage flag, a high interrupt and the compare value that was written.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 64;
    localparam int OFFS_LO_W = 32;
    localparam int OFFS_HI_W = 16;
    localparam int OFFS_W    = OFFS_LO_W + OFFS_HI_W;

    // byte addresses inside each frame
    localparam logic [11:0] A_REFRESH = 12'h000;
    localparam logic [11:0] A_CSR     = 12'h000;
    localparam logic [11:0] A_OFFS_LO = 12'h008;
    localparam logic [11:0] A_OFFS_HI = 12'h00C;
    localparam logic [11:0] A_CMP_LO  = 12'h010;
    localparam logic [11:0] A_CMP_HI  = 12'h014;
    localparam logic [11:0] A_IDENT   = 12'hFFC;

    // one-hot register select produced by the decoder
    typedef struct packed {
        logic refresh;
        logic ident_r;
        logic csr;
        logic offs_lo;
        logic offs_hi;
        logic cmp_lo;
        logic cmp_hi;
        logic ident_c;
    } wdog_hit_t;

    typedef struct packed {
        logic                 en;
        logic                 ws0;
        logic                 ws1;
        logic                 irq;
        logic                 armed;
        logic [OFFS_LO_W-1:0] offs_lo;
        logic [OFFS_HI_W-1:0] offs_hi;
        logic [CNT_W-1:0]     cmp;
        logic [CNT_W-1:0]     dl;
    } wdog_state_t;
endpackage

// File: rtl/wdog_decode.sv
`timescale 1ns/1ps
module wdog_decode
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              req,
    input  logic              frame,
    input  logic [ADDR_W-1:0] addr,
    output wdog_hit_t         hit
);
    localparam int ALIGN_BITS = 2;

    logic aligned;
    logic rfr_ok;
    logic ctl_ok;

    always_comb begin
        aligned = (addr[ALIGN_BITS-1:0] == '0);
        rfr_ok  = req && aligned && !frame;
        ctl_ok  = req && aligned && frame;

        hit         = '0;
        hit.refresh = rfr_ok && (addr == ADDR_W'(A_REFRESH));
        hit.ident_r = rfr_ok && (addr == ADDR_W'(A_IDENT));
        hit.csr     = ctl_ok && (addr == ADDR_W'(A_CSR));
        hit.offs_lo = ctl_ok && (addr == ADDR_W'(A_OFFS_LO));
        hit.offs_hi = ctl_ok && (addr == ADDR_W'(A_OFFS_HI));
        hit.cmp_lo  = ctl_ok && (addr == ADDR_W'(A_CMP_LO));
        hit.cmp_hi  = ctl_ok && (addr == ADDR_W'(A_CMP_HI));
        hit.ident_c = ctl_ok && (addr == ADDR_W'(A_IDENT));
    end
endmodule

// File: rtl/wdog_expiry.sv
`timescale 1ns/1ps
module wdog_expiry #(
    parameter int CNT_W = 64
) (
    input  logic             active,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] deadline,
    output logic             fire
);
    // at-or-past test so a counter that skips values still trips
    always_comb begin
        fire = active && (cnt >= deadline);
    end
endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/1ps
module wdog_core
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wdog_hit_t         hit,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              fire,
    output wdog_state_t       st_q
);
    wdog_state_t          st_d;
    logic                 do_ref;
    logic                 ro_hit;
    logic [CNT_W-1:0]     next_dl;

    always_comb begin
        st_d   = st_q;
        do_ref = 1'b0;
        ro_hit = hit.ident_r | hit.ident_c;

        if (wr && !ro_hit) begin
            if (hit.refresh) begin
                st_d.ws0 = 1'b0;
                st_d.ws1 = 1'b0;
                do_ref   = 1'b1;
            end
            if (hit.csr) begin
                st_d.en  = wdata[0];
                st_d.ws0 = 1'b0;
                st_d.ws1 = 1'b0;
                st_d.irq = 1'b0;
                do_ref   = 1'b1;
            end
            if (hit.offs_lo) begin
                st_d.offs_lo = wdata[OFFS_LO_W-1:0];
                st_d.ws0     = 1'b0;
                st_d.ws1     = 1'b0;
                st_d.irq     = 1'b0;
                do_ref       = 1'b1;
            end
            if (hit.offs_hi) begin
                st_d.offs_hi = wdata[OFFS_HI_W-1:0];
                st_d.ws0     = 1'b0;
                st_d.ws1     = 1'b0;
                st_d.irq     = 1'b0;
                do_ref       = 1'b1;
            end
            if (hit.cmp_lo) begin
                st_d.cmp[WORD_W-1:0] = wdata;
            end
            if (hit.cmp_hi) begin
                st_d.cmp[CNT_W-1:WORD_W] = wdata;
            end
        end

        // one adder serves both refresh (new offset) and re-arm (held offset)
        next_dl = cnt + CNT_W'({st_d.offs_hi, st_d.offs_lo});

        if (do_ref) begin
            st_d.armed = st_d.en;
            if (st_d.en) begin
                st_d.dl  = next_dl;
                st_d.cmp = next_dl;
            end
        end else if (fire) begin
            if (!st_q.ws0) begin
                st_d.ws0 = 1'b1;
                st_d.irq = 1'b1;
                st_d.dl  = next_dl;
            end else begin
                st_d.ws1   = 1'b1;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wdog_rdmux.sv
`timescale 1ns/1ps
module wdog_rdmux
    import wdog_pkg::*;
#(
    parameter logic [WORD_W-1:0] ID_VALUE = 32'h1A2B_0101
) (
    input  wdog_hit_t            hit,
    input  logic                 en,
    input  logic                 ws0,
    input  logic                 ws1,
    input  logic [OFFS_LO_W-1:0] offs_lo,
    input  logic [OFFS_HI_W-1:0] offs_hi,
    input  logic [CNT_W-1:0]     cmp,
    output logic [WORD_W-1:0]    rdata
);
    always_comb begin
        rdata = '0;
        if (hit.refresh) begin
            rdata = '0;
        end else if (hit.ident_r || hit.ident_c) begin
            rdata = ID_VALUE;
        end else if (hit.csr) begin
            rdata = WORD_W'({ws1, ws0, en});
        end else if (hit.offs_lo) begin
            rdata = WORD_W'(offs_lo);
        end else if (hit.offs_hi) begin
            rdata = WORD_W'(offs_hi);
        end else if (hit.cmp_lo) begin
            rdata = cmp[WORD_W-1:0];
        end else if (hit.cmp_hi) begin
            rdata = cmp[CNT_W-1:WORD_W];
        end
    end
endmodule

// File: rtl/wdog_top.sv
`timescale 1ns/1ps
module wdog_top
    import wdog_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [WORD_W-1:0] ID_VALUE = 32'h1A2B_0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sys_cnt,
    input  logic              bus_req,
    input  logic              bus_frame,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              wdog_irq,
    output logic              wdog_rst_req
);
    wdog_hit_t   hit;
    wdog_state_t st_q;
    logic        fire;
    logic        en_w;
    logic        ws0_w;
    logic        ws1_w;

    wdog_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req   (bus_req),
        .frame (bus_frame),
        .addr  (bus_addr),
        .hit   (hit)
    );

    wdog_expiry #(.CNT_W(CNT_W)) u_exp (
        .active   (st_q.en && st_q.armed),
        .cnt      (sys_cnt),
        .deadline (st_q.dl),
        .fire     (fire)
    );

    wdog_core u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .cnt   (sys_cnt),
        .fire  (fire),
        .st_q  (st_q)
    );

    wdog_rdmux #(.ID_VALUE(ID_VALUE)) u_rd (
        .hit     (hit),
        .en      (st_q.en),
        .ws0     (st_q.ws0),
        .ws1     (st_q.ws1),
        .offs_lo (st_q.offs_lo),
        .offs_hi (st_q.offs_hi),
        .cmp     (st_q.cmp),
        .rdata   (bus_rdata)
    );

    assign en_w         = st_q.en;
    assign ws0_w        = st_q.ws0;
    assign ws1_w        = st_q.ws1;
    assign wdog_irq     = st_q.irq;
    assign wdog_rst_req = st_q.ws1;
endmodule

// File: rtl/wdog_chk.sv
`timescale 1ns/1ps
module wdog_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_frame,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic              rst_req,
    input logic              en,
    input logic              ws0,
    input logic              ws1
);
    logic rfr_wr;
    logic csr_wr;
    logic rfr_rd;
    logic any_wr;

    assign rfr_wr = bus_req && bus_wr && !bus_frame && (bus_addr == '0);
    assign csr_wr = bus_req && bus_wr && bus_frame && (bus_addr == '0);
    assign rfr_rd = bus_req && !bus_wr && !bus_frame && (bus_addr == '0);
    assign any_wr = bus_req && bus_wr;

    AST_REFRESH_CLEARS_WS: assert property (@(posedge clk) disable iff (!rst_n)
        rfr_wr |=> (!ws0 && !ws1));                                          // R3

    AST_REFRESH_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rfr_rd |-> (bus_rdata == '0));                                       // R4

    AST_CSR_WRITE_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr |=> (!irq && !ws0 && !ws1));                                  // R5

    AST_FIRST_STAGE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ws0) |-> irq);                                                 // R7

    AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ws0);                                                    // R8

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !any_wr) |=> ($stable(ws0) && $stable(ws1) && $stable(irq))); // R9
endmodule

bind wdog_top wdog_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_frame (bus_frame),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (wdog_irq),
    .rst_req   (wdog_rst_req),
    .en        (en_w),
    .ws0       (ws0_w),
    .ws1       (ws1_w)
);

// File: tb/sim_wdog_top.sv
`timescale 1ns/1ps
module sim_wdog_top;
    localparam int          AW    = 12;
    localparam logic [31:0] IDV   = 32'h1A2B_0101;
    localparam logic [1:0]  OP_W  = 2'd0;
    localparam logic [1:0]  OP_R  = 2'd1;
    localparam logic [1:0]  OP_I  = 2'd2;
    localparam logic        RF    = 1'b0;
    localparam logic        CF    = 1'b1;
    localparam int          NV    = 36;

    typedef struct packed {
        logic [1:0]  op;
        logic        frame;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [63:0] cnt;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic        exp_rst;
        logic [3:0]  tag;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{OP_W, CF, 12'h008, 32'd100,       64'd1000,   32'd0,    1'b0, 1'b0, 4'd6},  // R6 offset, disabled
        '{OP_R, CF, 12'h008, 32'd0,         64'd1000,   32'd100,  1'b0, 1'b0, 4'd2},  // R2
        '{OP_W, CF, 12'h00C, 32'hFFFF_0002, 64'd1000,   32'd0,    1'b0, 1'b0, 4'd2},  // R2 high bits dropped
        '{OP_R, CF, 12'h00C, 32'd0,         64'd1000,   32'd2,    1'b0, 1'b0, 4'd2},  // R2
        '{OP_W, CF, 12'h00C, 32'd0,         64'd1000,   32'd0,    1'b0, 1'b0, 4'd2},  // R2
        '{OP_W, CF, 12'h000, 32'hFFFF_FFFF, 64'd1000,   32'd0,    1'b0, 1'b0, 4'd5},  // R5 enable
        '{OP_R, CF, 12'h000, 32'd0,         64'd1000,   32'd1,    1'b0, 1'b0, 4'd5},  // R5 only bit 0
        '{OP_R, CF, 12'h010, 32'd0,         64'd1000,   32'd1100, 1'b0, 1'b0, 4'd5},  // R5 refresh stored
        '{OP_R, CF, 12'h014, 32'd0,         64'd1000,   32'd0,    1'b0, 1'b0, 4'd5},  // R5
        '{OP_W, RF, 12'h000, 32'h1234_5678, 64'd1050,   32'd0,    1'b0, 1'b0, 4'd3},  // R3 refresh
        '{OP_R, CF, 12'h010, 32'd0,         64'd1050,   32'd1150, 1'b0, 1'b0, 4'd3},  // R3
        '{OP_R, RF, 12'h000, 32'd0,         64'd1050,   32'd0,    1'b0, 1'b0, 4'd4},  // R4
        '{OP_R, RF, 12'hFFC, 32'd0,         64'd1050,   IDV,      1'b0, 1'b0, 4'd1},  // R1
        '{OP_R, CF, 12'hFFC, 32'd0,         64'd1050,   IDV,      1'b0, 1'b0, 4'd1},  // R1
        '{OP_R, CF, 12'h020, 32'd0,         64'd1050,   32'd0,    1'b0, 1'b0, 4'd11}, // R11
        '{OP_W, CF, 12'h020, 32'hDEAD_BEEF, 64'd1050,   32'd0,    1'b0, 1'b0, 4'd11}, // R11
        '{OP_I, CF, 12'h000, 32'd0,         64'd1150,   32'd0,    1'b1, 1'b0, 4'd7},  // R7 first stage
        '{OP_R, CF, 12'h000, 32'd0,         64'd1150,   32'd3,    1'b1, 1'b0, 4'd7},  // R7
        '{OP_R, CF, 12'h010, 32'd0,         64'd1150,   32'd1150, 1'b1, 1'b0, 4'd7},  // R7 compare kept
        '{OP_I, CF, 12'h000, 32'd0,         64'd1250,   32'd0,    1'b1, 1'b1, 4'd8},  // R8 second stage
        '{OP_R, CF, 12'h000, 32'd0,         64'd1250,   32'd7,    1'b1, 1'b1, 4'd8},  // R8
        '{OP_W, RF, 12'h000, 32'd0,         64'd1300,   32'd0,    1'b1, 1'b0, 4'd3},  // R3 irq kept
        '{OP_R, CF, 12'h000, 32'd0,         64'd1300,   32'd1,    1'b1, 1'b0, 4'd3},  // R3
        '{OP_R, CF, 12'h010, 32'd0,         64'd1300,   32'd1400, 1'b1, 1'b0, 4'd3},  // R3
        '{OP_W, CF, 12'h008, 32'd50,        64'd1300,   32'd0,    1'b0, 1'b0, 4'd6},  // R6
        '{OP_R, CF, 12'h010, 32'd0,         64'd1300,   32'd1350, 1'b0, 1'b0, 4'd6},  // R6 new offset
        '{OP_W, CF, 12'h010, 32'd5000,      64'd1300,   32'd0,    1'b0, 1'b0, 4'd10}, // R10
        '{OP_R, CF, 12'h010, 32'd0,         64'd1300,   32'd5000, 1'b0, 1'b0, 4'd10}, // R10
        '{OP_I, CF, 12'h000, 32'd0,         64'd1350,   32'd0,    1'b1, 1'b0, 4'd10}, // R10 old deadline
        '{OP_R, CF, 12'h000, 32'd0,         64'd1350,   32'd3,    1'b1, 1'b0, 4'd10}, // R10
        '{OP_W, CF, 12'h000, 32'd0,         64'd1350,   32'd0,    1'b0, 1'b0, 4'd5},  // R5 disable
        '{OP_I, CF, 12'h000, 32'd0,         64'd100000, 32'd0,    1'b0, 1'b0, 4'd9},  // R9
        '{OP_R, CF, 12'h000, 32'd0,         64'd100000, 32'd0,    1'b0, 1'b0, 4'd9},  // R9
        '{OP_W, CF, 12'h009, 32'd7,         64'd100000, 32'd0,    1'b0, 1'b0, 4'd11}, // R11 unaligned
        '{OP_R, CF, 12'h008, 32'd0,         64'd100000, 32'd50,   1'b0, 1'b0, 4'd11}, // R11
        '{OP_R, CF, 12'h00A, 32'd0,         64'd100000, 32'd0,    1'b0, 1'b0, 4'd11}  // R11
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   sys_cnt = '0;
    logic          bus_req = 1'b0;
    logic          bus_frame = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          wdog_irq;
    logic          wdog_rst_req;
    int            n_cmp = 0;
    int            n_bad = 0;
    logic [31:0]   rd;

    always #2.5 clk = ~clk;

    wdog_top #(.ADDR_W(AW), .ID_VALUE(IDV)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .sys_cnt      (sys_cnt),
        .bus_req      (bus_req),
        .bus_frame    (bus_frame),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .wdog_irq     (wdog_irq),
        .wdog_rst_req (wdog_rst_req)
    );

    task automatic chk(input string what, input int tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic wr_op(input logic fr, input logic [11:0] a, input logic [31:0] d, input logic [63:0] c);
        @(negedge clk);
        sys_cnt   = c;
        bus_req   = 1'b1;
        bus_wr    = 1'b1;
        bus_frame = fr;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_req   = 1'b0;
        bus_wr    = 1'b0;
    endtask

    task automatic rd_now(input logic fr, input logic [11:0] a, output logic [31:0] d);
        bus_req   = 1'b1;
        bus_wr    = 1'b0;
        bus_frame = fr;
        bus_addr  = a;
        #0.2;
        d = bus_rdata;
        bus_req   = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("irq after reset", 1, 64'(wdog_irq), 64'd0);
        chk("rst_req after reset", 1, 64'(wdog_rst_req), 64'd0);
        rd_now(CF, 12'h000, rd); chk("csr after reset", 1, 64'(rd), 64'd0);
        rd_now(CF, 12'h010, rd); chk("cmp lo after reset", 1, 64'(rd), 64'd0);
        rd_now(CF, 12'h014, rd); chk("cmp hi after reset", 1, 64'(rd), 64'd0);
        @(negedge clk);
        rd_now(CF, 12'h008, rd); chk("offs lo after reset", 1, 64'(rd), 64'd0);
        rd_now(CF, 12'h00C, rd); chk("offs hi after reset", 1, 64'(rd), 64'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            sys_cnt = TBL[i].cnt;
            if (TBL[i].op != OP_I) begin
                bus_req   = 1'b1;
                bus_wr    = (TBL[i].op == OP_W);
                bus_frame = TBL[i].frame;
                bus_addr  = TBL[i].addr;
                bus_wdata = TBL[i].wdata;
            end
            #1;
            if (TBL[i].op == OP_R) chk("table read", int'(TBL[i].tag), 64'(bus_rdata), 64'(TBL[i].exp_rd));
            @(negedge clk);
            bus_req = 1'b0;
            bus_wr  = 1'b0;
            chk("table irq", int'(TBL[i].tag), 64'(wdog_irq), 64'(TBL[i].exp_irq));
            chk("table rst_req", int'(TBL[i].tag), 64'(wdog_rst_req), 64'(TBL[i].exp_rst));
        end

        // R12 refresh write on the deadline cycle: write wins
        wr_op(CF, 12'h000, 32'd1, 64'd3000);
        rd_now(CF, 12'h010, rd); chk("enable stores deadline", 5, 64'(rd), 64'd3050);
        wr_op(RF, 12'h000, 32'd0, 64'd3050);
        rd_now(CF, 12'h000, rd); chk("refresh beats hit csr", 12, 64'(rd), 64'd1);
        rd_now(CF, 12'h010, rd); chk("refresh beats hit cmp", 12, 64'(rd), 64'd3100);
        chk("refresh beats hit irq", 12, 64'(wdog_irq), 64'd0);

        // R12 compare write alongside first-stage hit
        wr_op(CF, 12'h010, 32'h0000_ABCD, 64'd3100);
        rd_now(CF, 12'h000, rd); chk("cmp write with hit csr", 12, 64'(rd), 64'd3);
        rd_now(CF, 12'h010, rd); chk("cmp write with hit cmp", 12, 64'(rd), 64'h0000_ABCD);
        chk("cmp write with hit irq", 12, 64'(wdog_irq), 64'd1);

        // R7 / R8 zero offset: both stages on successive edges
        wr_op(CF, 12'h008, 32'd0, 64'd3100);
        rd_now(CF, 12'h000, rd); chk("zero offset armed", 6, 64'(rd), 64'd1);
        chk("offset write drops irq", 6, 64'(wdog_irq), 64'd0);
        @(negedge clk);
        rd_now(CF, 12'h000, rd); chk("zero offset first stage", 7, 64'(rd), 64'd3);
        chk("zero offset irq", 7, 64'(wdog_irq), 64'd1);
        @(negedge clk);
        rd_now(CF, 12'h000, rd); chk("zero offset second stage", 8, 64'(rd), 64'd7);
        chk("zero offset rst_req", 8, 64'(wdog_rst_req), 64'd1);

        // R2 / R3 full 48-bit offset sum
        wr_op(CF, 12'h00C, 32'hFFFF_FFFF, 64'h0000_0001_0000_0000);
        wr_op(CF, 12'h008, 32'hFFFF_FFFF, 64'h0000_0001_0000_0000);
        rd_now(CF, 12'h010, rd); chk("wide sum cmp lo", 3, 64'(rd), 64'hFFFF_FFFF);
        rd_now(CF, 12'h014, rd); chk("wide sum cmp hi", 3, 64'(rd), 64'h0001_0000);
        rd_now(CF, 12'h00C, rd); chk("offs hi masked", 2, 64'(rd), 64'h0000_FFFF);
        @(negedge clk);
        rd_now(CF, 12'h000, rd); chk("offset write clears flags", 6, 64'(rd), 64'd1);
        chk("offset write clears rst_req", 6, 64'(wdog_rst_req), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule